// File: doc/BRIEF.md
# Saturating Bit-Count Classifier

The block takes a 40-bit data word and reports how many of its bits are set, but only up to a limit. The answer is one of five classes: none set, exactly one, exactly two, exactly three, or four and more. It suits control logic that needs to know whether a vector is empty, has one hot bit, or holds "many" bits, and that has no use for the exact count.

The word is cut into five 8-bit slices. Each slice has its own small counter whose result is clamped at four, so each slice needs only three bits. The five clamped slice counts are captured together in a single register stage. A merge step after that register adds them and clamps the total. The result and its valid flag therefore appear one clock after the word is sampled. Slice width, slice count and the clamp level are parameters. The defaults give the 40-bit, five-class form.

Top module: `popcount_class`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `out_class` is 0.
- R2: `out_valid` in a cycle equals `in_valid` one clock earlier, so every accepted word yields exactly one result after one clock.
- R3: When fewer than four bits of an accepted word are set, `out_class` one clock later equals the number of set bits (codes 0, 1, 2, 3).
- R4: When four or more bits of an accepted word are set, `out_class` one clock later is code 4. An all-ones word gives code 4.
- R5: `out_class` never takes the codes 5, 6 or 7.
- R6: Four or more set bits that all sit inside one 8-bit slice (bits 8k to 8k+7) give code 4, the same as when they are spread out.
- R7: Set bits in different slices are added together. One bit in each of three slices gives 3. One bit in each of four slices gives 4. Two bits in each of two slices give 4.
- R8: In a cycle where `in_valid` is 0 nothing is captured, and `out_class` keeps its previous value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The data word is to be sampled this cycle |
| in_data | input | 40 | Word whose set bits are counted |
| out_valid | output | 1 | `out_class` holds a new result |
| out_class | output | 3 | 0 to 3 for exact counts, 4 for four or more |

## Verification
The bench applies the all-zero word, which separates code 0 from a stuck class. It applies the all-ones word and a word with eight bits in one slice, which show whether the clamp holds with heavy input. Words with three bits against four bits, both packed into one slice and spread one per slice, show whether the limit falls at exactly four and whether slice-level clamping is told apart from the merge-level clamp. Sparse random words in back-to-back bursts and after idle gaps test the one-clock alignment and the hold while no word is accepted.

// File: rtl/popcount_class_pkg.sv
package popcount_class_pkg;
   localparam int unsigned PCC_SLICE_W_DEF = 8;
   localparam int unsigned PCC_N_SLICES_DEF = 5;
   localparam int unsigned PCC_SAT_DEF = 4;

   // bits needed to hold the values 0..max
   function automatic int unsigned pcc_width(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/pcc_slice_count.sv
module pcc_slice_count
   import popcount_class_pkg::*;
#(
   parameter int unsigned SLICE_W = PCC_SLICE_W_DEF,
   parameter int unsigned SAT     = PCC_SAT_DEF,
   localparam int unsigned OW     = pcc_width(SAT)
) (
   input  logic [SLICE_W-1:0] slice_bits,
   output logic [OW-1:0]      slice_cnt
);
   localparam int unsigned CW = pcc_width(SLICE_W);

   logic [CW-1:0] raw_cnt;

   always_comb begin
      raw_cnt = '0;
      for (int i = 0; i < SLICE_W; i++) begin
         raw_cnt = raw_cnt + CW'(slice_bits[i]);
      end
   end

   generate
      if (SLICE_W >= SAT) begin : g_clamp
         // a full slice can reach the limit: clamp locally
         assign slice_cnt = (raw_cnt >= CW'(SAT)) ? OW'(SAT) : OW'(raw_cnt);
      end else begin : g_direct
         // slice too narrow to reach the limit on its own
         assign slice_cnt = OW'(raw_cnt);
      end
   endgenerate
endmodule

// File: rtl/pcc_stage_reg.sv
module pcc_stage_reg #(
   parameter int unsigned N_SLICES = 5,
   parameter int unsigned OW       = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         d_valid,
   input  logic [N_SLICES-1:0][OW-1:0]  d_cnt,
   output logic                         q_valid,
   output logic [N_SLICES-1:0][OW-1:0]  q_cnt
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
         q_cnt   <= '0;
      end else begin
         q_valid <= d_valid;
         if (d_valid) begin
            q_cnt <= d_cnt;
         end
      end
   end
endmodule

// File: rtl/pcc_merge.sv
module pcc_merge
   import popcount_class_pkg::*;
#(
   parameter int unsigned N_SLICES = PCC_N_SLICES_DEF,
   parameter int unsigned SAT      = PCC_SAT_DEF,
   localparam int unsigned OW      = pcc_width(SAT)
) (
   input  logic [N_SLICES-1:0][OW-1:0] part_cnt,
   output logic [OW-1:0]               merged
);
   localparam int unsigned SUM_W = pcc_width(N_SLICES * SAT);

   logic [SUM_W-1:0] total;

   always_comb begin
      total = '0;
      for (int s = 0; s < N_SLICES; s++) begin
         total = total + SUM_W'(part_cnt[s]);
      end
   end

   // a slice already at SAT pushes the total to SAT or more by itself
   assign merged = (total >= SUM_W'(SAT)) ? OW'(SAT) : OW'(total);
endmodule

// File: rtl/popcount_class.sv
module popcount_class
   import popcount_class_pkg::*;
#(
   parameter int unsigned SLICE_W  = PCC_SLICE_W_DEF,
   parameter int unsigned N_SLICES = PCC_N_SLICES_DEF,
   parameter int unsigned SAT      = PCC_SAT_DEF
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           in_valid,
   input  logic [N_SLICES*SLICE_W-1:0]    in_data,
   output logic                           out_valid,
   output logic [pcc_width(SAT)-1:0]      out_class
);
   localparam int unsigned OW = pcc_width(SAT);

   generate
      if (SLICE_W < 1 || N_SLICES < 1) begin : g_bad_shape
         $error("popcount_class: slice width and slice count must be nonzero");
      end
      if (SAT < 1 || SAT > N_SLICES * SLICE_W) begin : g_bad_sat
         $error("popcount_class: clamp level must lie in 1..word width");
      end
   endgenerate

   logic [N_SLICES-1:0][OW-1:0] slice_cnt;
   logic [N_SLICES-1:0][OW-1:0] slice_cnt_q;

   generate
      for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
         pcc_slice_count #(
            .SLICE_W (SLICE_W),
            .SAT     (SAT)
         ) u_cnt (
            .slice_bits (in_data[s*SLICE_W +: SLICE_W]),
            .slice_cnt  (slice_cnt[s])
         );
      end
   endgenerate

   pcc_stage_reg #(
      .N_SLICES (N_SLICES),
      .OW       (OW)
   ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .d_valid (in_valid),
      .d_cnt   (slice_cnt),
      .q_valid (out_valid),
      .q_cnt   (slice_cnt_q)
   );

   pcc_merge #(
      .N_SLICES (N_SLICES),
      .SAT      (SAT)
   ) u_merge (
      .part_cnt (slice_cnt_q),
      .merged   (out_class)
   );
endmodule

// File: rtl/popcount_class_chk.sv
module popcount_class_chk
   import popcount_class_pkg::*;
#(
   parameter int unsigned SLICE_W  = PCC_SLICE_W_DEF,
   parameter int unsigned N_SLICES = PCC_N_SLICES_DEF,
   parameter int unsigned SAT      = PCC_SAT_DEF
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic [N_SLICES*SLICE_W-1:0] in_data,
   input logic                        out_valid,
   input logic [pcc_width(SAT)-1:0]   out_class
);
   localparam int unsigned OW = pcc_width(SAT);

   logic [OW-1:0] ref_cls;
   always_comb begin
      if ($countones(in_data) >= SAT) ref_cls = OW'(SAT);
      else                            ref_cls = OW'($countones(in_data));
   end

   // R2: valid follows one clock later
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R3, R4: class matches the clamped count of the word one clock earlier
   p_class_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_class == $past(ref_cls)));
   p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && $countones(in_data) >= SAT) |=> (out_class == OW'(SAT)));
   // R5: codes above the clamp never appear
   p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
      out_class <= OW'(SAT));
   // R8: idle cycle leaves the class untouched
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_class));
endmodule

bind popcount_class popcount_class_chk #(
   .SLICE_W  (SLICE_W),
   .N_SLICES (N_SLICES),
   .SAT      (SAT)
) u_popcount_class_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_class (out_class)
);

// File: tb/test_popcount_class.sv
module test_popcount_class;
   localparam int DW = 40;

   typedef struct {
      logic [2:0] exp;
      string      tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [2:0]    out_class;

   int n_chk = 0;
   int n_bad = 0;
   item_t sb[$];
   logic [2:0] last_cls = 3'd0;
   logic       mon_on = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   popcount_class i_popcount_class (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_class (out_class)
   );

   function automatic logic [2:0] model(input logic [DW-1:0] w);
      int c = 0;
      for (int i = 0; i < DW; i++) if (w[i]) c++;
      return (c >= 4) ? 3'd4 : 3'(c);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [DW-1:0] w, input string tag);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      it.exp = model(w);
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = {$urandom, $urandom};  // junk must not be captured (R8)
      end
   endtask

   // monitor: compares at negedge, away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 unexpected valid", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(out_class == it.exp, it.tag, out_class, it.exp);
               check(out_class <= 3'd4, "R5 code range", out_class, 4);
            end
         end else begin
            check(out_class == last_cls, "R8 hold while idle", out_class, last_cls);
         end
         last_cls = out_class;
      end
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
      check(out_class == 3'd0, "R1 class in reset", out_class, 0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
      check(out_class == 3'd0, "R1 class after reset", out_class, 0);
      mon_on = 1'b1;

      drive('0, "R3 all zero");
      drive({DW{1'b1}}, "R4 all ones");
      drive(40'h80_0000_0000, "R3 single MSB");
      drive(40'h00_0000_0101, "R3 two bits");
      drive(40'h00_0000_0007, "R6 three in one slice");
      drive(40'h00_0000_000F, "R6 four in one slice");
      drive(40'h00_FF00_0000, "R6 eight in one slice");
      idle(2);
      drive(40'h00_0101_0100, "R7 one per slice x3");
      drive(40'h01_0101_0100, "R7 one per slice x4");
      drive(40'h03_0000_0003, "R7 two per slice x2");
      drive(40'h80_4020_1008, "R7 one per slice x5");
      drive(40'h00_0000_0E00, "R3 three in slice 1");
      idle(3);
      drive(40'h10_0000_0000, "R3 one in slice 4");
      drive(40'h00_0000_0000, "R3 zero after one");

      for (int k = 0; k < 200; k++) begin
         logic [DW-1:0] w;
         w = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         if (k % 3 == 0) w = w & {$urandom, $urandom} & {$urandom, $urandom};
         drive(w, (model(w) == 3'd4) ? "R4 random" : "R3 random");
         if (k % 7 == 0) idle(1 + (k % 3));
      end

      idle(4);
      check(sb.size() == 0, "R2 results all delivered", sb.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule